// File: doc/BRIEF.md
# Five-Port Bidirectional GPIO Bank with Grouped Falling-Edge Interrupts

This block holds the pin controllers of a small microcontroller: five ports of eight pins each. Every pin has an output latch bit and a direction bit. Ports other than the open-drain port also have a pull-high enable bit. Software reaches all of this state through a single-cycle register bus. The pad side gets an output value, an output enable and a pull enable for each pin, and returns the raw pin level.

One port is fixed as open-drain. It can only sink current: a pin is driven low when it is an output and its latch bit is 0, and is released otherwise. It has no pull control. A second port acts as an interrupt source. Each of its pins can be enabled one by one for falling-edge detection. An enabled falling edge in the low nibble sets the first interrupt flag, and one in the high nibble sets the second. Each flag stays set until software writes a 1 to it.

Pin levels pass through a two-flop synchroniser. Data reads return the synchronised level for input pins and the latch value for output pins.

Top module: `gpio_bank`

## Requirements
- R1: After reset, every direction, pull-enable and edge-enable bit is 0 and both interrupt flags are 0. Every output latch of all five ports holds FFh, so setting a port's direction to all-outputs right after reset drives FFh on ports 1 to 4 and leaves port 0 fully released.
- R2: A read of a port's data register returns, for each bit, the latch value where the direction bit is 1 (output) and the synchronised pad level where it is 0 (input). A pad change is visible in a read three clock edges after it occurs.
- R3: For ports 1 to 4, the pad output equals the latch, and the pad output enable equals the direction register, from the cycle after the write.
- R4: For ports 1 to 4, the pad pull enable equals that port's pull register, which reads back as written.
- R5: Port 0 is open-drain. Its pad output is always 0, and its output enable is set only where the direction bit is 1 and the latch bit is 0. Its pull enables are always 0, and its pull register reads 0 whatever was written to it.
- R6: A 1-to-0 transition of the synchronised level on port 1 pin b, with edge-enable bit b set, sets flag bit 0 (INT2, output irq_int2) for b in 0..3 and flag bit 1 (INT3, output irq_int3) for b in 4..7. The flag is visible three clock edges after the pad falls.
- R7: Falling edges on pins whose edge-enable bit is 0 never set a flag, and rising edges on any pin never set a flag.
- R8: Writing the flag register clears each flag whose written bit is 1 and leaves each flag whose written bit is 0 unchanged.
- R9: If a clearing write and a new enabled falling edge in the same group land in the same cycle, the flag ends up set.
- R10: Address layout: bits [4:3] select the register kind (0 data, 1 direction, 2 pull, 3 special) and bits [2:0] select the port. Special address 18h is the edge-enable register and 19h is the flag register (bit 0 INT2, bit 1 INT3, other bits read 0). Every address with no register reads 0.
- R11: bus_rdata is registered: it presents the register selected by bus_addr at one clock edge after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe for the register bus |
| bus_addr | input | 5 | Register address (kind in [4:3], port in [2:0]) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pad_in | input | 40 | Raw pin levels, port p at bits [8p+7:8p] |
| pad_out | output | 40 | Pin output values |
| pad_oe | output | 40 | Pin output enables |
| pad_pu | output | 40 | Pin pull-high enables |
| irq_int2 | output | 1 | Latched INT2 flag (port 1 low nibble) |
| irq_int3 | output | 1 | Latched INT3 flag (port 1 high nibble) |

## Verification
The bench sweeps latch, direction and pad patterns over all five ports, computing the mixed input/output readback bit by bit. A wrong readback mux would return the latch on input pins. An open-drain port that followed the normal port logic would drive highs. Every port 1 pin is tested for falling edges with its enable on and with it off, and for rising edges. A wrong nibble split would raise the other flag, and a missing enable gate would flag masked pins. Clearing is exercised with write-1 bits, with write-0 bits, and in the same cycle as a fresh edge. A design that gave the clear priority would lose that interrupt.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int KIND_W = 2;

  typedef enum logic [KIND_W-1:0] {
    K_DATA = 2'd0,
    K_DIR  = 2'd1,
    K_PULL = 2'd2,
    K_SPEC = 2'd3
  } reg_kind_e;

  localparam int SPEC_EDGE_EN = 0;
  localparam int SPEC_FLAGS   = 1;
  localparam int NUM_GROUPS   = 2;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_port.sv
module gpio_port #(
  parameter int         W          = 8,
  parameter bit         OPEN_DRAIN = 1'b0,
  parameter logic [W-1:0] RST_LATCH = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         data_we,
  input  logic         dir_we,
  input  logic         pull_we,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] pin_sync,
  output logic [W-1:0] rd_data,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] pull_q,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] pad_pu
);
  logic [W-1:0] latch_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q <= RST_LATCH;
      dir_q   <= '0;
    end else begin
      if (data_we) latch_q <= wdata;
      if (dir_we)  dir_q   <= wdata;
    end
  end

  assign rd_data = (dir_q & latch_q) | (~dir_q & pin_sync);

  generate
    if (OPEN_DRAIN) begin : g_od
      assign pad_out = '0;
      assign pad_oe  = dir_q & ~latch_q;
      assign pull_q  = '0;
      logic unused_pull;
      assign unused_pull = pull_we;
    end else begin : g_pp
      logic [W-1:0] pull_r;
      always_ff @(posedge clk) begin
        if (rst)          pull_r <= '0;
        else if (pull_we) pull_r <= wdata;
      end
      assign pad_out = latch_q;
      assign pad_oe  = dir_q;
      assign pull_q  = pull_r;
    end
  endgenerate

  assign pad_pu = pull_q;
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq #(
  parameter int W      = 8,
  parameter int GROUPS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_we,
  input  logic              flag_we,
  input  logic [W-1:0]      wdata,
  input  logic [W-1:0]      pin_sync,
  output logic [W-1:0]      en_q,
  output logic [GROUPS-1:0] flag_q
);
  localparam int GW = W / GROUPS;

  logic [W-1:0]      prev_q;
  logic [W-1:0]      fall;
  logic [GROUPS-1:0] grp_hit;
  logic [GROUPS-1:0] clr;

  assign fall = prev_q & ~pin_sync & en_q;

  generate
    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
      assign grp_hit[g] = |fall[g*GW +: GW];
    end
  endgenerate

  assign clr = flag_we ? wdata[GROUPS-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      en_q   <= '0;
      flag_q <= '0;
    end else begin
      prev_q <= pin_sync;
      if (en_we) en_q <= wdata;
      flag_q <= (flag_q & ~clr) | grp_hit;
    end
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank #(
  parameter int NPORTS      = 5,
  parameter int W           = 8,
  parameter int OD_PORT     = 0,
  parameter int IRQ_PORT    = 1,
  parameter int SYNC_STAGES = 2,
  parameter int PAW         = $clog2(NPORTS),
  parameter int AW          = gpio_pkg::KIND_W + PAW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [AW-1:0]     bus_addr,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  input  logic [NPORTS*W-1:0] pad_in,
  output logic [NPORTS*W-1:0] pad_out,
  output logic [NPORTS*W-1:0] pad_oe,
  output logic [NPORTS*W-1:0] pad_pu,
  output logic              irq_int2,
  output logic              irq_int3
);
  import gpio_pkg::*;

  localparam int TW = NPORTS * W;

  reg_kind_e      kind;
  logic [PAW-1:0] pidx;
  assign kind = reg_kind_e'(bus_addr[AW-1 -: KIND_W]);
  assign pidx = bus_addr[PAW-1:0];

  logic [TW-1:0] pin_sync;
  gpio_sync #(.W(TW), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pad_in), .q(pin_sync)
  );

  logic [W-1:0] rd_a   [NPORTS];
  logic [W-1:0] dir_a  [NPORTS];
  logic [W-1:0] pull_a [NPORTS];

  generate
    for (genvar p = 0; p < NPORTS; p++) begin : g_port
      logic sel;
      assign sel = (pidx == PAW'(p));
      gpio_port #(
        .W(W), .OPEN_DRAIN(p == OD_PORT), .RST_LATCH({W{1'b1}})
      ) u_port (
        .clk(clk), .rst(rst),
        .data_we(bus_we && sel && kind == K_DATA),
        .dir_we (bus_we && sel && kind == K_DIR),
        .pull_we(bus_we && sel && kind == K_PULL),
        .wdata(bus_wdata),
        .pin_sync(pin_sync[p*W +: W]),
        .rd_data(rd_a[p]),
        .dir_q(dir_a[p]),
        .pull_q(pull_a[p]),
        .pad_out(pad_out[p*W +: W]),
        .pad_oe(pad_oe[p*W +: W]),
        .pad_pu(pad_pu[p*W +: W])
      );
    end
  endgenerate

  logic [W-1:0]          edge_en;
  logic [NUM_GROUPS-1:0] flags;
  logic                  spec_en_sel, spec_flag_sel;

  assign spec_en_sel   = (kind == K_SPEC) && (pidx == PAW'(SPEC_EDGE_EN));
  assign spec_flag_sel = (kind == K_SPEC) && (pidx == PAW'(SPEC_FLAGS));

  gpio_edge_irq #(.W(W), .GROUPS(NUM_GROUPS)) u_irq (
    .clk(clk), .rst(rst),
    .en_we(bus_we && spec_en_sel),
    .flag_we(bus_we && spec_flag_sel),
    .wdata(bus_wdata),
    .pin_sync(pin_sync[IRQ_PORT*W +: W]),
    .en_q(edge_en),
    .flag_q(flags)
  );

  assign irq_int2 = flags[0];
  assign irq_int3 = flags[1];

  logic [W-1:0] rd_next;
  always_comb begin
    rd_next = '0;
    for (int p = 0; p < NPORTS; p++) begin
      if (pidx == PAW'(p)) begin
        case (kind)
          K_DATA:  rd_next = rd_a[p];
          K_DIR:   rd_next = dir_a[p];
          K_PULL:  rd_next = pull_a[p];
          default: rd_next = '0;
        endcase
      end
    end
    if (spec_en_sel)   rd_next = edge_en;
    if (spec_flag_sel) rd_next = W'(flags);
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_next;
  end
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
  parameter int NPORTS   = 5,
  parameter int W        = 8,
  parameter int OD_PORT  = 0,
  parameter int IRQ_PORT = 1,
  parameter int PAW      = 3,
  parameter int AW       = 5
) (
  input logic                clk,
  input logic                rst,
  input logic                bus_we,
  input logic [AW-1:0]       bus_addr,
  input logic [W-1:0]        bus_wdata,
  input logic [NPORTS*W-1:0] pad_out,
  input logic [NPORTS*W-1:0] pad_oe,
  input logic [NPORTS*W-1:0] pad_pu,
  input logic                irq_int2,
  input logic                irq_int3
);
  localparam logic [AW-1:0] FLAG_ADDR = {2'd3, PAW'(1)};

  generate
    for (genvar p = 0; p < NPORTS; p++) begin : g_chk
      if (p != OD_PORT) begin : g_pp
        a_r3_dir_to_oe: assert property (@(posedge clk) disable iff (rst)
          (bus_we && bus_addr == {2'd1, PAW'(p)}) |=> pad_oe[p*W +: W] == $past(bus_wdata));
        a_r3_data_to_out: assert property (@(posedge clk) disable iff (rst)
          (bus_we && bus_addr == {2'd0, PAW'(p)}) |=> pad_out[p*W +: W] == $past(bus_wdata));
        a_r4_pull_to_pad: assert property (@(posedge clk) disable iff (rst)
          (bus_we && bus_addr == {2'd2, PAW'(p)}) |=> pad_pu[p*W +: W] == $past(bus_wdata));
      end
    end
  endgenerate

  a_r5_od_no_drive_high: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == {2'd0, PAW'(OD_PORT)}) |=>
      ((pad_oe[OD_PORT*W +: W] & $past(bus_wdata)) == '0));

  a_r8_int2_fall_needs_clear: assert property (@(posedge clk) disable iff (rst)
    $fell(irq_int2) |-> $past(bus_we && bus_addr == FLAG_ADDR && bus_wdata[0]));

  a_r8_int3_fall_needs_clear: assert property (@(posedge clk) disable iff (rst)
    $fell(irq_int3) |-> $past(bus_we && bus_addr == FLAG_ADDR && bus_wdata[1]));
endmodule

bind gpio_bank gpio_bank_chk #(
  .NPORTS(NPORTS), .W(W), .OD_PORT(OD_PORT), .IRQ_PORT(IRQ_PORT), .PAW(PAW), .AW(AW)
) u_chk (
  .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu),
  .irq_int2(irq_int2), .irq_int3(irq_int3)
);

// File: tb/gpio_bank_tb_top.sv
module gpio_bank_tb_top;
  localparam int NP = 5;
  localparam int W  = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_we = 1'b0;
  logic [4:0]    bus_addr = '0;
  logic [7:0]    bus_wdata = '0;
  logic [7:0]    bus_rdata;
  logic [NP*W-1:0] pad_in = '1;
  logic [NP*W-1:0] pad_out, pad_oe, pad_pu;
  logic          irq_int2, irq_int3;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  gpio_bank dut_i (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu),
    .irq_int2(irq_int2), .irq_int3(irq_int3)
  );

  function automatic logic [4:0] ad(input int kind, input int port);
    return {kind[1:0], port[2:0]};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] v);
    @(negedge clk);
    bus_addr = a;
    @(posedge clk);
    @(negedge clk);
    v = bus_rdata;
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    chk(pad_oe == '0, "R1 oe", pad_oe, 0);
    chk(pad_pu == '0, "R1 pu", pad_pu, 0);
    chk({irq_int3, irq_int2} == 2'b00, "R1 irq", {irq_int3, irq_int2}, 0);
    for (int p = 0; p < NP; p++) begin
      rd(ad(1, p), v); chk(v == 8'h00, "R1 dir", v, 0);
      rd(ad(2, p), v); chk(v == 8'h00, "R1 pull", v, 0);
    end
    rd(ad(3, 0), v); chk(v == 8'h00, "R1 edge_en", v, 0);
    rd(ad(3, 1), v); chk(v == 8'h00, "R1 flags", v, 0);
    for (int p = 0; p < NP; p++) wr(ad(1, p), 8'hFF);
    for (int p = 1; p < NP; p++)
      chk(pad_out[p*W +: W] == 8'hFF, "R1 latch FFh", pad_out[p*W +: W], 8'hFF);
    chk(pad_oe[7:0] == 8'h00, "R1 port0 latch FFh", pad_oe[7:0], 0);

    // R2, R3, R5: latch/direction/pad sweep
    for (int p = 0; p < NP; p++) begin
      for (int i = 0; i < 8; i++) begin
        logic [7:0] d, m, q, e;
        d = 8'(i * 8'h35) ^ 8'h0F;
        m = 8'(i * 8'h49 + p);
        q = ~8'(i * 8'h1D + p * 3);
        wr(ad(0, p), d);
        wr(ad(1, p), m);
        pad_in[p*W +: W] = q;
        settle();
        e = (m & d) | (~m & q);
        rd(ad(0, p), v);
        chk(v == e, "R2 readback", v, e);
        if (p == 0) begin
          chk(pad_out[7:0] == 8'h00, "R5 od out", pad_out[7:0], 0);
          chk(pad_oe[7:0] == (m & ~d), "R5 od oe", pad_oe[7:0], m & ~d);
        end else begin
          chk(pad_out[p*W +: W] == d, "R3 out", pad_out[p*W +: W], d);
          chk(pad_oe[p*W +: W] == m, "R3 oe", pad_oe[p*W +: W], m);
        end
      end
    end

    // R4, R5: pull enables
    for (int p = 0; p < NP; p++) begin
      logic [7:0] pv, e;
      pv = 8'(8'hC3 ^ (p * 8'h11));
      wr(ad(2, p), pv);
      e = (p == 0) ? 8'h00 : pv;
      rd(ad(2, p), v);
      chk(v == e, (p == 0) ? "R5 pull reg" : "R4 pull reg", v, e);
      chk(pad_pu[p*W +: W] == e, (p == 0) ? "R5 pull pad" : "R4 pull pad", pad_pu[p*W +: W], e);
    end

    // R10: unmapped addresses read 0
    rd(ad(0, 5), v); chk(v == 8'h00, "R10 unmapped data", v, 0);
    rd(ad(3, 2), v); chk(v == 8'h00, "R10 unmapped spec", v, 0);
    rd(ad(1, 7), v); chk(v == 8'h00, "R10 unmapped dir", v, 0);

    // R6, R7, R8: per-pin falling edges on port 1
    pad_in[15:8] = 8'hFF;
    settle();
    wr(ad(3, 1), 8'h03);
    for (int b = 0; b < 8; b++) begin
      logic [1:0] eg;
      eg = (b < 4) ? 2'b01 : 2'b10;
      // enabled falling edge
      wr(ad(3, 0), 8'hFF);
      pad_in[8 + b] = 1'b0;
      settle();
      rd(ad(3, 1), v);
      chk(v == {6'd0, eg}, "R6 flag group", v, eg);
      chk({irq_int3, irq_int2} == eg, "R6 irq pins", {irq_int3, irq_int2}, eg);
      // write 0 leaves flags
      wr(ad(3, 1), 8'h00);
      chk({irq_int3, irq_int2} == eg, "R8 write0 keeps", {irq_int3, irq_int2}, eg);
      // rising edge does not set
      wr(ad(3, 1), 8'h03);
      pad_in[8 + b] = 1'b1;
      settle();
      chk({irq_int3, irq_int2} == 2'b00, "R7 rising / R8 cleared", {irq_int3, irq_int2}, 0);
      // disabled pin falling edge does not set
      wr(ad(3, 0), ~(8'h01 << b));
      pad_in[8 + b] = 1'b0;
      settle();
      chk({irq_int3, irq_int2} == 2'b00, "R7 disabled pin", {irq_int3, irq_int2}, 0);
      pad_in[8 + b] = 1'b1;
      settle();
    end

    // R8: selective clear
    wr(ad(3, 0), 8'hFF);
    pad_in[8] = 1'b0; pad_in[12] = 1'b0;
    settle();
    chk({irq_int3, irq_int2} == 2'b11, "R6 both groups", {irq_int3, irq_int2}, 3);
    wr(ad(3, 1), 8'h02);
    chk({irq_int3, irq_int2} == 2'b01, "R8 clear INT3 only", {irq_int3, irq_int2}, 1);

    // R9: clear and new edge in the same cycle
    @(negedge clk);
    pad_in[9] = 1'b0;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = ad(3, 1); bus_wdata = 8'h01;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
    chk(irq_int2 == 1'b1, "R9 edge wins clear", irq_int2, 1);
    wr(ad(3, 1), 8'h01);
    chk(irq_int2 == 1'b0, "R8 clear INT2", irq_int2, 0);

    // R11: one-edge read latency
    @(negedge clk);
    bus_addr = ad(1, 2);
    @(posedge clk);
    @(negedge clk);
    v = bus_rdata;
    bus_addr = ad(2, 2);
    chk(v == 8'(2 * 8'h49 - 8'h49 * 2 + 8'(7 * 8'h49 + 2)), "R11 latency dir", v, 8'(7 * 8'h49 + 2));
    @(posedge clk);
    @(negedge clk);
    chk(bus_rdata == 8'(8'hC3 ^ 8'h22), "R11 latency pull", bus_rdata, 8'(8'hC3 ^ 8'h22));

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule